// File: doc/BRIEF.md
# Folded Bit-Array Convolution Engine

This block convolves two 3-element bit arrays into a 5-element bit array. Each result bit is the logical OR, over every pairing, of one bit of the first array ANDed with one bit of the second array. The two indices of a pairing always add up to the result index, and any index that falls outside the arrays counts as a zero bit. The arithmetic is folded in time. The second array sits in a register padded with zeros on both sides and slides one place per output index. The first array stays fixed while result bits are gathered into a shift register.

A build-time parameter picks one of two forms. The serial form has one AND gate and one OR gate. A feedback accumulator builds each result bit from three products, so one bit is produced every three cycles. The semi-parallel form has three AND gates that work together, and it produces one result bit per cycle. A single-cycle request captures both operands. A one-cycle completion pulse marks the moment the last result bit lands.

Top module: `bitconv_fold`

## Requirements
- R1: When an operation completes, bit i of `z_out` (i = 0..4) equals the OR over j = 0..2 of `x_in[j] & y_in[i-j]`, as captured at the accepted request. Terms whose y index lies outside 0..2 are zero.
- R2: With `SERIAL=1`, `busy` rises on the edge that accepts a request and stays high for exactly 15 cycles. One result bit is shifted in on every third busy edge.
- R3: With `SERIAL=0`, `busy` stays high for exactly 5 cycles and one result bit is shifted in on every busy edge.
- R4: An accepted request clears `z_out`. Each new result bit enters at bit 4 while the word shifts toward bit 0, so z0 ends in bit 0 and z4 in bit 4.
- R5: `done` is high for exactly one cycle. It is high in the cycle right after the last result bit is shifted in, which is also the first cycle in which `busy` is low.
- R6: A `start` seen while `busy` is high is ignored. The operands of the running operation are kept, and so is its timing.
- R7: While `busy` is low and no request is accepted, `z_out` holds its value whatever `x_in` and `y_in` do.
- R8: During reset, `busy`, `done` and `z_out` are all zero.
- R9: In the serial form, no partial result carries from one output index into the next. For example, x=001 and y=001 give exactly 00001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted on a rising edge when `busy` is low |
| x_in | input | N | First operand array, element j in bit j |
| y_in | input | N | Second operand array, element j in bit j |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| z_out | output | 2N-1 | Result shift register, element i in bit i when complete |

## Verification
Every pair of operands is run through both forms. A design that used the wrong tap of the padded register, or lost the zero padding at either end, would therefore show wrong bits at z0 or z4. A request raised while busy tests that the operands are not taken again. If the design captured them anyway, the result would switch to the second operand pair and the busy window would grow longer. A request held high across the done cycle exercises a restart in the very next cycle, which a design that ignored requests while done is high would miss. A one-bit pattern that follows a window full of ones would expose an accumulator that is not cleared: z1 would be set wrongly.

// File: rtl/bitconv_fold.sv
module bitconv_fold #(
  parameter int N      = 3,
  parameter bit SERIAL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   x_in,
  input  logic [N-1:0]   y_in,
  output logic           busy,
  output logic           done,
  output logic [2*N-2:0] z_out
);
  localparam int NZ = 2*N - 1;
  localparam int YW = 3*N - 2;
  localparam int IW = (NZ > 1) ? $clog2(NZ) : 1;
  localparam int TW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  xr;
  logic [YW-1:0] ysr;
  logic [IW-1:0] idx;
  logic          zbit;
  logic          bit_rdy;
  logic          go;
  logic          last_bit;
  logic [N-1:0]  win;

  assign go       = start & ~busy;
  assign last_bit = bit_rdy && (idx == IW'(NZ-1));
  assign win      = ysr[N-1:0];

  generate
    if (SERIAL) begin : g_serial
      logic [TW-1:0] tap;
      logic [TW-1:0] mirror;
      logic          acc;
      logic          prod;

      assign mirror  = TW'(N-1) - tap;
      assign prod    = xr[tap] & win[mirror];
      assign zbit    = acc | prod;
      assign bit_rdy = busy && (tap == TW'(N-1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tap <= '0;
          acc <= 1'b0;
        end else if (go) begin
          tap <= '0;
          acc <= 1'b0;
        end else if (busy) begin
          if (bit_rdy) begin
            tap <= '0;
            acc <= 1'b0;
          end else begin
            tap <= tap + TW'(1);
            acc <= acc | prod;
          end
        end
      end
    end else begin : g_semi
      logic [N-1:0] win_rev;
      for (genvar j = 0; j < N; j++) begin : g_tap
        assign win_rev[j] = win[N-1-j];
      end
      assign zbit    = |(xr & win_rev);
      assign bit_rdy = busy;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      xr    <= '0;
      ysr   <= '0;
      z_out <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy  <= 1'b1;
        idx   <= '0;
        xr    <= x_in;
        ysr   <= {{(YW-N){1'b0}}, y_in} << (N-1);
        z_out <= '0;
      end else if (bit_rdy) begin
        z_out <= {zbit, z_out[NZ-1:1]};
        ysr   <= ysr >> 1;
        if (last_bit) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("AST_DONE_SINGLE"); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))) else $error("AST_DONE_ENDS_BUSY"); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(xr)) else $error("AST_START_IGNORED"); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(z_out)) else $error("AST_IDLE_HOLD"); // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> (busy && z_out == '0)) else $error("AST_START_CLEARS"); // R4
endmodule

// File: tb/test_bitconv_fold.sv
module test_bitconv_fold;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] x_in = '0;
  logic [2:0] y_in = '0;
  logic busy_s, done_s, busy_p, done_p;
  logic [4:0] z_s, z_p;

  int checks = 0;
  int fails = 0;
  bit checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitconv_fold #(.N(3), .SERIAL(1'b1)) i_bitconv_fold (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .busy(busy_s), .done(done_s), .z_out(z_s));

  bitconv_fold #(.N(3), .SERIAL(1'b0)) i_bitconv_fold_semi (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .busy(busy_p), .done(done_p), .z_out(z_p));

  function automatic logic [4:0] conv(input logic [2:0] a, input logic [2:0] b);
    logic [4:0] r = '0;
    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 3; j++)
        if (i - j >= 0 && i - j <= 2) r[i] = r[i] | (a[j] & b[i-j]);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, index 0 = serial, 1 = semi-parallel
  bit         m_busy[2];
  bit         m_done[2];
  logic [4:0] m_z[2];
  logic [4:0] m_exp[2];
  int         m_cnt[2];
  int         m_k[2];

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        m_busy[m] = 0; m_done[m] = 0; m_z[m] = '0; m_cnt[m] = 0; m_k[m] = 0;
      end else begin
        m_done[m] = 0;
        if (m_busy[m]) begin
          m_cnt[m]++;
          if (m_cnt[m] % (m == 0 ? 3 : 1) == 0) begin
            m_z[m] = {m_exp[m][m_k[m]], m_z[m][4:1]};
            m_k[m]++;
            if (m_k[m] == 5) begin
              m_busy[m] = 0;
              m_done[m] = 1;
            end
          end
        end else if (start) begin
          m_busy[m] = 1; m_cnt[m] = 0; m_k[m] = 0; m_z[m] = '0;
          m_exp[m] = conv(x_in, y_in);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk("R2 serial busy", {4'b0, busy_s}, {4'b0, m_busy[0]});
      chk("R3 semi busy", {4'b0, busy_p}, {4'b0, m_busy[1]});
      chk("R5 serial done", {4'b0, done_s}, {4'b0, m_done[0]});
      chk("R5 semi done", {4'b0, done_p}, {4'b0, m_done[1]});
      chk("R4 serial z_out", z_s, m_z[0]);
      chk("R4 semi z_out", z_p, m_z[1]);
    end
  end

  task automatic launch(input logic [2:0] a, input logic [2:0] b);
    @(negedge clk);
    start = 1'b1; x_in = a; y_in = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_tests;
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {3'b0, busy_s, busy_p}, 5'b0);
    chk("R8 reset done", {3'b0, done_s, done_p}, 5'b0);
    chk("R8 reset z_out serial", z_s, 5'b0);
    chk("R8 reset z_out semi", z_p, 5'b0);
    rst_n = 1'b1;
    checking = 1'b1;

    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        launch(3'(a), 3'(b));
        repeat (16) @(negedge clk);
        chk("R1 serial result", z_s, conv(3'(a), 3'(b)));
        chk("R1 semi result", z_p, conv(3'(a), 3'(b)));
      end

    launch(3'b111, 3'b111);
    repeat (16) @(negedge clk);
    launch(3'b001, 3'b001);
    repeat (16) @(negedge clk);
    chk("R9 no carry serial", z_s, 5'b00001);

    launch(3'b111, 3'b001);
    @(negedge clk);
    start = 1'b1; x_in = 3'b000; y_in = 3'b000;
    @(negedge clk);
    start = 1'b0;
    repeat (14) @(negedge clk);
    chk("R6 serial keeps operands", z_s, 5'b00111);
    chk("R6 semi keeps operands", z_p, 5'b00111);

    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      x_in = 3'(t); y_in = 3'(7 - t);
    end
    chk("R7 serial idle hold", z_s, 5'b00111);
    chk("R7 semi idle hold", z_p, 5'b00111);

    @(negedge clk);
    start = 1'b1; x_in = 3'b101; y_in = 3'b011;
    repeat (40) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 restart serial", z_s, conv(3'b101, 3'b011));
    chk("R1 restart semi", z_p, conv(3'b101, 3'b011));
    checking = 1'b0;
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule